// File: doc/BRIEF.md
# Power-Mode Sequencer with Serial Shutdown Command

This block governs the power state of a driver device. From power-down, asserting the active-low chip-select starts the oscillator. The first oscillator cycles are then filtered by a debounce interval, and the device becomes operational only if chip-select is held asserted for the whole interval. Releasing chip-select earlier sends the device back to power-down.

Shutdown is a serial command. A mode 0 frame of eight bits is sent MSB first, and its upper three bits carry the opcode; opcode 4 requests shutdown. The request stays armed only until chip-select is released. The release then starts a standby countdown: the drivers are stopped so that stored antenna energy can decay, while the oscillator keeps running. When the countdown expires, the oscillator stops and the drivers go high-impedance. Re-asserting chip-select during the countdown cancels it, and the device stays awake. Releasing chip-select with no armed request only deselects the serial port, and the device keeps operating.

All inputs are sampled in the oscillator clock domain through synchronizers. The serial clock must therefore stay high and low for at least two oscillator cycles each. Every output is decoded from the registered state, so none of them glitches on input activity. There is no data stream at the block's edge, so it has no valid/ready handshake. Every pin is a plain level.

Top module: `psq_power_seq`

## Requirements
- R1: After the asynchronous reset the block is in power-down: pwr_state=0, osc_en=0, drv_en=0, drv_hiz=1.
- R2: Asserting cs_n (low) in power-down moves the block to debounce: pwr_state=1, osc_en=1, drv_en=0, drv_hiz=0.
- R3: Debounce lasts exactly DEB_CYCLES clock cycles (default 64) while cs_n stays low, then the block enters operational (pwr_state=2).
- R4: Releasing cs_n during debounce returns the block to power-down (pwr_state=0, osc_en=0).
- R5: Operational drives pwr_state=2, osc_en=1, drv_en=1, drv_hiz=0. drv_en is 1 in no other state, and drv_hiz is 1 only in power-down.
- R6: In operational, a complete 8-bit frame whose bits [7:5] equal 3'b100 arms shutdown. Bits are sampled on the rising edge of sck while cs_n is low, MSB first. Releasing cs_n then enters the standby countdown: pwr_state=3, osc_en=1, drv_en=0, drv_hiz=0.
- R7: Releasing cs_n when shutdown is not armed leaves the block operational.
- R8: The standby countdown lasts exactly STBY_CYCLES clock cycles (default 2048) and then enters power-down.
- R9: Asserting cs_n during the countdown returns the block to operational and clears the request, so a later release without a new command keeps it operational.
- R10: A frame cut short by cs_n release is discarded: it neither arms nor disarms shutdown.
- R11: Only the last complete frame in a selection counts. A frame with another opcode (for example 0xA0) sent after the shutdown frame disarms the request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| cs_n | input | 1 | Chip-select, active low |
| sck | input | 1 | Serial clock, mode 0 |
| sdi | input | 1 | Serial data in, MSB first |
| osc_en | output | 1 | Oscillator enable |
| drv_en | output | 1 | Driver stage enable |
| drv_hiz | output | 1 | Driver outputs high-impedance |
| pwr_state | output | 2 | 0 power-down, 1 debounce, 2 operational, 3 standby countdown |

## Verification
All outputs are decoded from the state register, so a wrong state shows on pwr_state and the enables one cycle after the faulty transition. A miscounting interval counter only shows as a debounce or countdown of the wrong length, and that appears once the interval ends. For that reason both intervals are measured cycle by cycle. A wrong armed flag stays hidden until chip-select is released, which the synchronizer delays by two cycles. After that it shows as a countdown that should not have started, or one that is missing.

// File: rtl/psq_pkg.sv
package psq_pkg;
  typedef enum logic [1:0] {
    PS_OFF  = 2'd0,
    PS_DEB  = 2'd1,
    PS_RUN  = 2'd2,
    PS_STBY = 2'd3
  } psq_state_e;

  localparam int OPC_W = 3;
  localparam logic [OPC_W-1:0] OPC_SHUTDOWN = 3'd4;
endpackage

// File: rtl/psq_sync.sv
module psq_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/psq_spi_rx.sv
module psq_spi_rx #(
  parameter int FRAME_BITS = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  en,
  input  logic                  sck,
  input  logic                  sdi,
  output logic                  done,
  output logic [FRAME_BITS-1:0] data
);
  localparam int BC_W = $clog2(FRAME_BITS);

  logic                  sck_q;
  logic [BC_W-1:0]       bitcnt;
  logic [FRAME_BITS-1:0] shreg;
  logic                  rise;
  logic [FRAME_BITS-1:0] shnext;

  assign rise   = en && sck && !sck_q;
  assign shnext = {shreg[FRAME_BITS-2:0], sdi};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q  <= 1'b0;
      bitcnt <= '0;
      shreg  <= '0;
      done   <= 1'b0;
      data   <= '0;
    end else begin
      sck_q <= sck;
      done  <= 1'b0;
      if (!en) begin
        bitcnt <= '0;
      end else if (rise) begin
        shreg <= shnext;
        if (bitcnt == BC_W'(FRAME_BITS-1)) begin
          bitcnt <= '0;
          done   <= 1'b1;
          data   <= shnext;
        end else begin
          bitcnt <= bitcnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/psq_interval.sv
module psq_interval #(
  parameter int CW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  output logic [CW-1:0] cnt
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt <= '0;
    else if (clear) cnt <= '0;
    else            cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/psq_power_seq.sv
module psq_power_seq #(
  parameter int DEB_CYCLES  = 64,
  parameter int STBY_CYCLES = 2048,
  parameter int SYNC_STAGES = 2,
  parameter int FRAME_BITS  = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_n,
  input  logic       sck,
  input  logic       sdi,
  output logic       osc_en,
  output logic       drv_en,
  output logic       drv_hiz,
  output logic [1:0] pwr_state
);
  import psq_pkg::*;

  localparam int MAXC = (DEB_CYCLES > STBY_CYCLES) ? DEB_CYCLES : STBY_CYCLES;
  localparam int CW   = $clog2(MAXC + 1);

  logic [2:0] raw_in, syn_in;
  logic       cs_act, sck_s, sdi_s;
  psq_state_e st_q, st_d;
  logic       armed;
  logic       frm_done;
  logic [FRAME_BITS-1:0] frm_data;
  logic [CW-1:0] cnt;
  logic       cnt_clear;

  assign raw_in = {cs_n, sck, sdi};

  psq_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw_in), .q(syn_in)
  );

  assign cs_act = !syn_in[2];
  assign sck_s  = syn_in[1];
  assign sdi_s  = syn_in[0];

  psq_spi_rx #(.FRAME_BITS(FRAME_BITS)) u_rx (
    .clk(clk), .rst_n(rst_n), .en(cs_act && (st_q == PS_RUN)),
    .sck(sck_s), .sdi(sdi_s), .done(frm_done), .data(frm_data)
  );

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      PS_OFF:  if (cs_act) st_d = PS_DEB;
      PS_DEB:  if (!cs_act) st_d = PS_OFF;
               else if (cnt == CW'(DEB_CYCLES-1)) st_d = PS_RUN;
      PS_RUN:  if (!cs_act && armed) st_d = PS_STBY;
      PS_STBY: if (cs_act) st_d = PS_RUN;
               else if (cnt == CW'(STBY_CYCLES-1)) st_d = PS_OFF;
      default: st_d = PS_OFF;
    endcase
  end

  assign cnt_clear = (st_d != st_q) || (st_q == PS_OFF) || (st_q == PS_RUN);

  psq_interval #(.CW(CW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .clear(cnt_clear), .cnt(cnt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= PS_OFF;
      armed <= 1'b0;
    end else begin
      st_q <= st_d;
      if (st_q != PS_RUN)
        armed <= 1'b0;
      else if (frm_done)
        armed <= (frm_data[FRAME_BITS-1 -: OPC_W] == OPC_SHUTDOWN);
    end
  end

  assign pwr_state = st_q;
  assign osc_en    = (st_q != PS_OFF);
  assign drv_en    = (st_q == PS_RUN);
  assign drv_hiz   = (st_q == PS_OFF);
endmodule

// File: rtl/psq_power_seq_chk.sv
module psq_power_seq_chk #(
  parameter int DEB_CYCLES  = 64,
  parameter int STBY_CYCLES = 2048
) (
  input logic       clk,
  input logic       rst_n,
  input logic       cs_act,
  input logic       osc_en,
  input logic       drv_en,
  input logic       drv_hiz,
  input logic [1:0] pwr_state
);
  int unsigned deb_run, stby_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      deb_run  <= 0;
      stby_run <= 0;
    end else begin
      deb_run  <= (pwr_state == 2'd1) ? deb_run + 1 : 0;
      stby_run <= (pwr_state == 2'd3) ? stby_run + 1 : 0;
    end
  end

  p_off_only_to_deb_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_state == 2'd0 && cs_act) |=> (pwr_state == 2'd1));
  p_deb_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_state == 2'd1) |-> (deb_run < DEB_CYCLES));
  p_deb_abort_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_state == 2'd1 && !cs_act) |=> (pwr_state == 2'd0));
  p_pins_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (drv_hiz |-> !osc_en) and (drv_en |-> !drv_hiz));
  p_run_exit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_state == 2'd2 && cs_act) |=> (pwr_state == 2'd2));
  p_stby_len_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_state == 2'd3) |-> (stby_run < STBY_CYCLES));
  p_stby_abort_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_state == 2'd3 && cs_act) |=> (pwr_state == 2'd2));
endmodule

bind psq_power_seq psq_power_seq_chk #(
  .DEB_CYCLES(DEB_CYCLES), .STBY_CYCLES(STBY_CYCLES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_act(cs_act), .osc_en(osc_en),
  .drv_en(drv_en), .drv_hiz(drv_hiz), .pwr_state(pwr_state)
);

// File: tb/tb_psq_power_seq.sv
`timescale 1ns/1ps
module tb_psq_power_seq;
  localparam int DEB  = 64;
  localparam int STBY = 2048;

  logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, sck = 1'b0, sdi = 1'b0;
  logic osc_en, drv_en, drv_hiz;
  logic [1:0] pwr_state;

  int total = 0, bad = 0;
  bit finished = 1'b0;

  typedef struct { string tag; logic [4:0] exp; } item_t;
  item_t q[$];

  always #10 clk = ~clk;

  psq_power_seq #(.DEB_CYCLES(DEB), .STBY_CYCLES(STBY)) dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .sdi(sdi),
    .osc_en(osc_en), .drv_en(drv_en), .drv_hiz(drv_hiz), .pwr_state(pwr_state)
  );

  // monitor: compares queued expectations with the outputs after each falling edge
  initial forever begin
    @(negedge clk);
    #1;
    while (q.size() > 0) begin
      item_t it;
      logic [4:0] act;
      it  = q.pop_front();
      act = {pwr_state, osc_en, drv_en, drv_hiz};
      total++;
      if (act !== it.exp) begin
        bad++;
        $display("FAIL %s: state/osc/drv/hiz actual=%b expected=%b", it.tag, act, it.exp);
      end
    end
  end

  function automatic logic [4:0] vec(input int st);
    case (st)
      0: return {2'd0, 3'b001};
      1: return {2'd1, 3'b100};
      2: return {2'd2, 3'b110};
      default: return {2'd3, 3'b100};
    endcase
  endfunction

  task automatic expect_st(input string tag, input int st);
    item_t it;
    it.tag = tag;
    it.exp = vec(st);
    q.push_back(it);
    @(negedge clk);
  endtask

  task automatic check_val(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_st(input int st, input int lim);
    for (int i = 0; i < lim && pwr_state != st; i++) @(negedge clk);
  endtask

  task automatic measure(input int st, output int n);
    n = 0;
    while (pwr_state == st && n < 100000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic send_bits(input logic [7:0] b, input int nb);
    for (int i = 7; i > 7 - nb; i--) begin
      sdi = b[i];
      sck = 1'b0;
      idle(2);
      sck = 1'b1;
      idle(2);
    end
    sck = 1'b0;
    idle(2);
  endtask

  task automatic power_up();
    cs_n = 1'b0;
    wait_st(2, DEB + 20);
  endtask

  initial begin
    int n;
    idle(2);
    expect_st("R1 reset", 0);
    rst_n = 1'b1;
    idle(3);
    expect_st("R1 after reset release", 0);

    // R2 / R3 / R5
    cs_n = 1'b0;
    wait_st(1, 10);
    expect_st("R2 debounce outputs", 1);
    measure(1, n);
    check_val("R3 debounce length", n + 1, DEB);
    expect_st("R5 operational outputs", 2);

    // R7: other opcode, release
    send_bits(8'h20, 8);
    cs_n = 1'b1;
    idle(10);
    expect_st("R7 release without command", 2);

    // R6 / R8
    cs_n = 1'b0;
    idle(3);
    send_bits(8'h80, 8);
    cs_n = 1'b1;
    wait_st(3, 10);
    expect_st("R6 standby after shutdown frame", 3);
    measure(3, n);
    check_val("R8 standby length", n + 1, STBY);
    expect_st("R8 power-down after countdown", 0);

    // R4: short selection during debounce
    cs_n = 1'b0;
    wait_st(1, 10);
    idle(5);
    cs_n = 1'b1;
    idle(5);
    expect_st("R4 debounce abort", 0);
    idle(5);
    expect_st("R4 stays down", 0);

    // R10: full shutdown frame, then a cut frame -> still standby
    power_up();
    expect_st("R3 power up again", 2);
    send_bits(8'h9F, 8);
    send_bits(8'h00, 3);
    cs_n = 1'b1;
    wait_st(3, 10);
    expect_st("R10 cut frame does not disarm", 3);

    // R9: abort countdown
    idle(100);
    cs_n = 1'b0;
    idle(5);
    expect_st("R9 countdown abort", 2);
    cs_n = 1'b1;
    idle(10);
    expect_st("R9 request cleared", 2);

    // R11: later frame disarms
    cs_n = 1'b0;
    idle(3);
    send_bits(8'h80, 8);
    send_bits(8'hA0, 8);
    cs_n = 1'b1;
    idle(10);
    expect_st("R11 last frame decides", 2);

    // R10: cut shutdown frame alone does not arm
    cs_n = 1'b0;
    idle(3);
    send_bits(8'h80, 5);
    cs_n = 1'b1;
    idle(10);
    expect_st("R10 cut frame does not arm", 2);

    // R6 with other low bits, then full power-down
    cs_n = 1'b0;
    idle(3);
    send_bits(8'h8C, 8);
    cs_n = 1'b1;
    wait_st(3, 10);
    expect_st("R6 opcode in upper bits only", 3);
    wait_st(0, STBY + 10);
    expect_st("R1 down again", 0);

    idle(2);
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule